// File: doc/BRIEF.md
# Burst Column Sequencer with Read Latency

This block drives the column side of one bank of a synchronous graphics memory whose rows are 256 columns wide. A command decoder hands it one-cycle read, write and burst-stop strobes together with a start column. The block then issues one column per clock in the programmed order and flags which of those columns are write beats. For reads it produces a data-valid strobe delayed by the programmed CAS latency, so the read-data capture path knows when each beat appears.

A mode register holds four settings: the CAS latency, the burst length, the burst order, and a flag that limits every write to one beat. A burst takes its length and order when its command is registered, so loading the mode register never disturbs a burst already in flight. A new read or write restarts the engine. This lets a read cut a write short, and it lets back-to-back commands chain without idle cycles.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `burst_act`, `col_wr` and `rd_dvalid` are low. The mode register resets to CAS latency 1, length code 0 (one beat), linear order and single-beat writes off.
- R2: A read column issued in the cycle after clock edge k produces `rd_dvalid` high in the cycle after edge k+L, where L is `mode_cl` (codes 1, 2 and 3; code 0 behaves as 1). Write columns never raise `rd_dvalid`.
- R3: `mode_bl` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. For a burst whose command is registered at edge 0, `burst_act` is high for exactly that many cycles after edge 0, and the first `col_addr` equals `start_col`.
- R4: With `mode_ilv`=0 and N beats, beat i addresses the aligned N-column block holding the start column, at offset (start offset + i) mod N.
- R5: With `mode_ilv`=1 and N beats, beat i addresses the same aligned block at offset (start offset XOR i).
- R6: `mode_bl` codes 4 to 7 select a full page. The column then counts up by one modulo 256 whatever the order setting, and the burst runs until a burst stop or a new command.
- R7: With `mode_single_wr`=1, every write burst is one beat long, and read bursts keep their programmed length.
- R8: A burst stop with no read or write in the same cycle drops `burst_act` and `col_wr` from the next cycle on. Read beats already issued still produce their `rd_dvalid` pulses.
- R9: A read registered during a write burst ends the write at once. From the next cycle `col_wr` is low and the read's columns are issued.
- R10: A read or write during an active burst restarts from the new `start_col`. When read and write (and stop) arrive together, the read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load the mode fields into the mode register |
| mode_cl | input | 2 | CAS latency code |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear |
| mode_single_wr | input | 1 | 1 = writes are one beat |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| stop_cmd | input | 1 | Burst stop strobe |
| start_col | input | 8 | Start column of a read or write |
| col_addr | output | 8 | Column of the current beat (valid while burst_act) |
| col_wr | output | 1 | Current beat is a write beat |
| rd_dvalid | output | 1 | Read data valid, delayed by the CAS latency |
| burst_act | output | 1 | A column is issued this cycle |

## Verification
Two functions collide when a read command is registered on a cycle in which a write beat is being issued. The write must stop in the next cycle, and the read must start there from its own column. The bench provokes this by driving a read on the second beat of an eight-beat write. It judges the result by `col_wr` falling in the very next cycle, `col_addr` jumping to the read's start, and the first `rd_dvalid` arriving exactly one latency later. A second collision puts read, write and stop in one cycle during a read burst, and the read must be the command that takes effect.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int CL_W = 2;
    localparam int BL_W = 3;

    typedef struct packed {
        logic [CL_W-1:0] cl;
        logic [BL_W-1:0] bl;
        logic            ilv;
        logic            single_wr;
    } mode_t;

    localparam mode_t MODE_RST = '{cl: 2'd1, bl: 3'd0, ilv: 1'b0, single_wr: 1'b0};
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  mode_t wdata,
    output mode_t mode
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load) mode_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RST;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [BL_W-1:0]  bl,
    input  logic             ilv,
    output logic [COL_W-1:0] col,
    output logic             last
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] off;

    always_comb begin
        mask = ~({COL_W{1'b1}} << bl[1:0]);
        off  = ilv ? ((base ^ cnt) & mask) : ((base + cnt) & mask);
        if (bl[BL_W-1]) begin
            col  = base + cnt;
            last = 1'b0;
        end else begin
            col  = (base & ~mask) | off;
            last = (cnt == mask);
        end
    end
endmodule

// File: rtl/bcs_lat_pipe.sv
module bcs_lat_pipe #(
    parameter int MAX_LAT = 3,
    parameter int LAT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [LAT_W-1:0] lat,
    output logic             out_vld
);
    logic [MAX_LAT-1:0] sr_d, sr_q;
    int unsigned tap;

    assign sr_d[0] = in_vld;

    generate
        for (genvar s = 1; s < MAX_LAT; s++) begin : g_stage
            assign sr_d[s] = sr_q[s-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    always_comb begin
        if (lat == '0)                      tap = 0;
        else if (int'(lat) > MAX_LAT)       tap = MAX_LAT - 1;
        else                                tap = int'(lat) - 1;
        out_vld = sr_q[tap];
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [CL_W-1:0]  mode_cl,
    input  logic [BL_W-1:0]  mode_bl,
    input  logic             mode_ilv,
    input  logic             mode_single_wr,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             stop_cmd,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] col_addr,
    output logic             col_wr,
    output logic             rd_dvalid,
    output logic             burst_act
);
    typedef struct packed {
        logic             act;
        logic             wr;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [BL_W-1:0]  bl;
        logic             ilv;
    } seq_t;

    mode_t mode_w, mode_q;
    seq_t  st_d, st_q;
    logic  last_beat;
    logic  rd_issue;
    logic [CL_W-1:0] cur_cl;
    logic            cur_single;

    assign mode_w = '{cl: mode_cl, bl: mode_bl, ilv: mode_ilv, single_wr: mode_single_wr};

    bcs_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .wdata (mode_w),
        .mode  (mode_q)
    );

    assign cur_cl     = mode_q.cl;
    assign cur_single = mode_q.single_wr;

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base (st_q.base),
        .cnt  (st_q.cnt),
        .bl   (st_q.bl),
        .ilv  (st_q.ilv),
        .col  (col_addr),
        .last (last_beat)
    );

    always_comb begin
        st_d = st_q;
        if (rd_cmd || wr_cmd) begin
            st_d.act  = 1'b1;
            st_d.wr   = !rd_cmd;
            st_d.base = start_col;
            st_d.cnt  = '0;
            st_d.bl   = (!rd_cmd && mode_q.single_wr) ? '0 : mode_q.bl;
            st_d.ilv  = mode_q.ilv;
        end else if (stop_cmd) begin
            st_d.act = 1'b0;
            st_d.wr  = 1'b0;
        end else if (st_q.act) begin
            if (last_beat) begin
                st_d.act = 1'b0;
                st_d.wr  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign burst_act = st_q.act;
    assign col_wr    = st_q.act & st_q.wr;
    assign rd_issue  = st_q.act & !st_q.wr;

    bcs_lat_pipe #(.MAX_LAT(MAX_CL), .LAT_W(CL_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (rd_issue),
        .lat     (mode_q.cl),
        .out_vld (rd_dvalid)
    );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic             rd_cmd,
    input logic             wr_cmd,
    input logic             stop_cmd,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_addr,
    input logic             col_wr,
    input logic             rd_dvalid,
    input logic             burst_act,
    input logic [1:0]       cfg_cl,
    input logic             cfg_single
);
    p_start_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd || wr_cmd) |=> (burst_act && col_addr == $past(start_col)));

    p_rd_ends_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (burst_act && !col_wr));

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !rd_cmd && !wr_cmd) |=> (!burst_act && !col_wr));

    p_cl1_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cl == 2'd1 && burst_act && !col_wr && !mode_load) |=> rd_dvalid);

    p_cl1_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cl == 2'd1 && !burst_act && !mode_load) |=> !rd_dvalid);

    p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !rd_cmd && cfg_single) ##1 (!rd_cmd && !wr_cmd) |=> !col_wr);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_load  (mode_load),
    .rd_cmd     (rd_cmd),
    .wr_cmd     (wr_cmd),
    .stop_cmd   (stop_cmd),
    .start_col  (start_col),
    .col_addr   (col_addr),
    .col_wr     (col_wr),
    .rd_dvalid  (rd_dvalid),
    .burst_act  (burst_act),
    .cfg_cl     (cur_cl),
    .cfg_single (cur_single)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [1:0] mode_cl = 2'd1;
    logic [2:0] mode_bl = 3'd0;
    logic       mode_ilv = 1'b0;
    logic       mode_single_wr = 1'b0;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0, stop_cmd = 1'b0;
    logic [7:0] start_col = 8'd0;
    logic [7:0] col_addr;
    logic       col_wr, rd_dvalid, burst_act;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    burst_col_seq uut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_cl(mode_cl),
        .mode_bl(mode_bl), .mode_ilv(mode_ilv), .mode_single_wr(mode_single_wr),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .stop_cmd(stop_cmd), .start_col(start_col),
        .col_addr(col_addr), .col_wr(col_wr), .rd_dvalid(rd_dvalid), .burst_act(burst_act)
    );

    // {cl[15:14], bl[13:11], ilv[10], single[9], wr[8], start[7:0]}
    localparam logic [15:0] VEC [13] = '{
        {2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h05},
        {2'd2, 3'd1, 1'b0, 1'b0, 1'b0, 8'h07},
        {2'd3, 3'd2, 1'b0, 1'b0, 1'b0, 8'h0E},
        {2'd1, 3'd3, 1'b0, 1'b0, 1'b0, 8'h1D},
        {2'd2, 3'd1, 1'b1, 1'b0, 1'b0, 8'h21},
        {2'd3, 3'd2, 1'b1, 1'b0, 1'b0, 8'h36},
        {2'd2, 3'd3, 1'b1, 1'b0, 1'b0, 8'h4B},
        {2'd1, 3'd4, 1'b0, 1'b0, 1'b0, 8'hFA},
        {2'd3, 3'd7, 1'b1, 1'b0, 1'b0, 8'hFC},
        {2'd2, 3'd3, 1'b0, 1'b1, 1'b1, 8'h90},
        {2'd2, 3'd2, 1'b0, 1'b1, 1'b0, 8'h11},
        {2'd1, 3'd3, 1'b1, 1'b0, 1'b1, 8'h62},
        {2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 8'h80}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int start, input int bl, input int ilv, input int i);
        int n, blk, so;
        if (bl >= 4) return (start + i) % 256;
        n   = 1 << bl;
        blk = start - (start % n);
        so  = start % n;
        return ilv ? blk + (so ^ i) : blk + ((so + i) % n);
    endfunction

    task automatic load_mode(input int cl, input int bl, input int ilv, input int sgl);
        mode_cl = 2'(cl); mode_bl = 3'(bl); mode_ilv = 1'(ilv); mode_single_wr = 1'(sgl);
        mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic run_vec(input logic [15:0] v);
        int cl, bl, ilv, sgl, wr, st, ecl, nb;
        logic full;
        cl = int'(v[15:14]); bl = int'(v[13:11]); ilv = int'(v[10]);
        sgl = int'(v[9]); wr = int'(v[8]); st = int'(v[7:0]);
        full = (bl >= 4);
        ecl = (cl == 0) ? 1 : cl;
        nb  = full ? 12 : ((wr != 0 && sgl != 0) ? 1 : (1 << bl));
        load_mode(cl, bl, ilv, sgl);
        rd_cmd = (wr == 0); wr_cmd = (wr != 0); start_col = 8'(st);
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        for (int k = 0; k < nb + 5; k++) begin
            chk("R3 burst_act", 32'(burst_act), 32'(k < nb));
            chk("R7/R3 col_wr", 32'(col_wr), 32'(wr != 0 && k < nb));
            chk("R2 rd_dvalid", 32'(rd_dvalid), 32'(wr == 0 && k >= ecl && k < ecl + nb));
            if (k < nb)
                chk(full ? "R6 col_addr" : (ilv != 0 ? "R5 col_addr" : "R4 col_addr"),
                    32'(col_addr), 32'(exp_col(st, bl, ilv, k)));
            if (full && k == nb - 1) stop_cmd = 1'b1;
            @(negedge clk);
            stop_cmd = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: outputs quiet during and after reset
        repeat (2) @(negedge clk);
        chk("R1 burst_act in reset", 32'(burst_act), 0);
        chk("R1 col_wr in reset", 32'(col_wr), 0);
        chk("R1 rd_dvalid in reset", 32'(rd_dvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 burst_act after reset", 32'(burst_act), 0);
        chk("R1 rd_dvalid after reset", 32'(rd_dvalid), 0);
        // R1: default mode is one beat, latency 1
        rd_cmd = 1'b1; start_col = 8'h33;
        @(negedge clk);
        rd_cmd = 1'b0;
        chk("R1 default first col", 32'(col_addr), 32'h33);
        chk("R1 default act", 32'(burst_act), 1);
        @(negedge clk);
        chk("R1 default one beat", 32'(burst_act), 0);
        chk("R1 default latency 1", 32'(rd_dvalid), 1);
        @(negedge clk);
        chk("R1 default dvalid ends", 32'(rd_dvalid), 0);
        repeat (2) @(negedge clk);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R8: stop on the third beat of an 8-beat read, latency 3
        load_mode(3, 3, 0, 0);
        rd_cmd = 1'b1; start_col = 8'h00;
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R8 burst_act", 32'(burst_act), 32'(k < 3));
            chk("R8 rd_dvalid drains", 32'(rd_dvalid), 32'(k >= 3 && k < 6));
            if (k < 3) chk("R8 col_addr", 32'(col_addr), 32'(k));
            if (k == 2) stop_cmd = 1'b1;
            @(negedge clk);
            stop_cmd = 1'b0;
        end

        // R9: read cuts an 8-beat write on its second beat, latency 2
        load_mode(2, 3, 0, 0);
        wr_cmd = 1'b1; start_col = 8'h10;
        @(negedge clk);
        wr_cmd = 1'b0;
        chk("R9 write beat0", 32'(col_wr), 1);
        @(negedge clk);
        chk("R9 write beat1 col", 32'(col_addr), 32'h11);
        rd_cmd = 1'b1; start_col = 8'h40;
        @(negedge clk);
        rd_cmd = 1'b0;
        chk("R9 col_wr drops", 32'(col_wr), 0);
        chk("R9 read active", 32'(burst_act), 1);
        chk("R9 read start col", 32'(col_addr), 32'h40);
        chk("R9 no dvalid yet", 32'(rd_dvalid), 0);
        @(negedge clk);
        chk("R9 read second col", 32'(col_addr), 32'h41);
        chk("R9 no dvalid at 1", 32'(rd_dvalid), 0);
        @(negedge clk);
        chk("R9 first dvalid", 32'(rd_dvalid), 1);
        repeat (12) @(negedge clk);

        // R10: read, write and stop together during a read burst
        load_mode(1, 2, 0, 0);
        rd_cmd = 1'b1; start_col = 8'h08;
        @(negedge clk);
        chk("R10 first col", 32'(col_addr), 32'h08);
        wr_cmd = 1'b1; stop_cmd = 1'b1; start_col = 8'h51;
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0; stop_cmd = 1'b0;
        chk("R10 restart col", 32'(col_addr), 32'h51);
        chk("R10 read wins", 32'(col_wr), 0);
        chk("R10 still active", 32'(burst_act), 1);
        @(negedge clk);
        chk("R10 next col", 32'(col_addr), 32'h52);
        repeat (8) @(negedge clk);
        chk("R10 idle after", 32'(burst_act), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule